// File: doc/BRIEF.md
# Receiver Status Buffer with Half-Region Flags

This block sits behind the bit decoder of a digital audio receiver. The decoder hands it three serial streams, each a data bit with a one-cycle strobe: channel-status bits, user bits and auxiliary bits. The block packs each stream into bytes, first-received bit in bit 0, and stores the bytes in a small byte-wide buffer. A host reads that buffer over a synchronous parallel port. The port has a select, a read/write strobe, a 5-bit address and 8-bit write and read data buses. Through the same port the host reads a sticky status register and writes an interrupt-enable register and two control registers.

A two-bit buffer-mode field picks how the upper part of the buffer is divided between channel status and auxiliary data. The user region never moves. Three level flags tell the host which half of a region the receiver is filling, so the host can read the other half without a race. A further flag marks that a full channel-status block has arrived. Error events and the completion flag's rising edge set sticky bits that a status read clears. Enabled sticky bits pull an active-low interrupt.

Top module: `rxbuf_top`

## Requirements
- R1: After reset, `flag` is 000, `irq_n` is 1, and reads of addresses 0 to 3 and of any buffer byte return 00h.
- R2: Address 1 (interrupt enable) keeps bits [3:0] and reads bits [7:4] as zero. Addresses 2 and 3 read back the full byte last written. Bits [1:0] of address 2 are the buffer mode.
- R3: Channel-status bytes are stored from address 08h upward, first-received bit in bit 0. The region is 24 bytes (08h–1Fh) in mode 0 and 8 bytes (08h–0Fh) in modes 1, 2 and 3. The write index wraps to the start after the last byte.
- R4: User bytes are stored at 04h–07h in every mode, first-received bit in bit 0, and wrap after 07h.
- R5: In mode 1, auxiliary bytes are stored at 10h–1Fh. In every other mode, auxiliary strobes are ignored and 10h–1Fh keep their contents.
- R6: `flag[0]` is 1 while the receiver fills the upper half of the user region (bytes 06h–07h). `flag[1]` is 1 while it fills the upper half of the channel-status region.
- R7: `flag[2]` goes to 1 on the edge that stores the last channel-status byte of the region. It goes to 0 on the edge after `blk_start`. `blk_start` also restarts every stream at the first byte and the first bit.
- R8: Status bits [2:0] at address 0 latch `err_evt[2:0]`. A host read of address 0 returns the current value and clears the bits. If an event arrives in the same cycle as the clearing read, the event's bit stays set.
- R9: Status bit 3 is set only by a rising edge of `flag[2]`. It is not set again while `flag[2]` stays high.
- R10: `irq_n` is 0 exactly when some status bit and the matching enable bit are both 1.
- R11: A host read of a buffer byte in the same cycle that the receiver stores that byte returns the old value. The next read returns the new value.
- R12: Host writes to addresses 04h–1Fh have no effect on the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| blk_start | input | 1 | Start of a new channel-status block; restarts all streams |
| chs_stb | input | 1 | Channel-status bit strobe |
| chs_bit | input | 1 | Channel-status bit |
| usr_stb | input | 1 | User bit strobe |
| usr_bit | input | 1 | User bit |
| aux_stb | input | 1 | Auxiliary bit strobe |
| aux_bit | input | 1 | Auxiliary bit |
| err_evt | input | 3 | Error event pulses, one per status bit |
| h_cs | input | 1 | Host access select |
| h_rd | input | 1 | 1 = read, 0 = write |
| h_addr | input | 5 | Host address |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, valid the cycle after the read |
| flag | output | 3 | [0] user half, [1] channel-status half, [2] block complete |
| irq_n | output | 1 | Interrupt, active low |

## Verification
The hardest case to reach from the ports is a host read that lands on the same edge where a stream stores a byte into the address being read. The bench counts strobes: it sends seven bits of a user byte, then drives the eighth strobe and a read of 04h in the same cycle. It expects the old byte first and the new byte on the following read. An error pulse placed in the same cycle as a clearing status read gets the same treatment. The bench also checks that an auxiliary byte sent in a non-auxiliary mode leaves the old byte in place.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;

    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 8;
    localparam int IDX_W    = 5;
    localparam int N_ERR    = 3;
    localparam int N_STS    = N_ERR + 1;
    localparam int N_STREAM = 3;
    localparam int MEM_LO   = 4;
    localparam int MEM_HI   = (1 << ADDR_W) - 1;

    localparam int S_CHS = 0;
    localparam int S_USR = 1;
    localparam int S_AUX = 2;

    localparam logic [ADDR_W-1:0] A_STS  = 5'h00;
    localparam logic [ADDR_W-1:0] A_IEN  = 5'h01;
    localparam logic [ADDR_W-1:0] A_CTL1 = 5'h02;
    localparam logic [ADDR_W-1:0] A_CTL2 = 5'h03;

    typedef enum logic [1:0] {
        BM_CHS_LONG  = 2'd0,
        BM_CHS_AUX   = 2'd1,
        BM_CHS_SHORT = 2'd2,
        BM_SPARE     = 2'd3
    } bufmode_e;

    typedef struct packed {
        logic              en;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } wr_t;

    typedef struct packed {
        logic              sel;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } host_t;

    function automatic logic [ADDR_W-1:0] region_base(input int s);
        case (s)
            S_CHS:   return 5'h08;
            S_USR:   return 5'h04;
            default: return 5'h10;
        endcase
    endfunction

    function automatic logic [IDX_W-1:0] region_len(input int s, input bufmode_e m);
        case (s)
            S_CHS:   return (m == BM_CHS_LONG) ? 5'd24 : 5'd8;
            S_USR:   return 5'd4;
            default: return 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/rxbuf_assembler.sv
module rxbuf_assembler
    import rxbuf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             stb,
    input  logic             din,
    input  logic [IDX_W-1:0] len,
    output wr_t              wr,
    output logic [IDX_W-1:0] cur_idx
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-2:0] shreg;
    logic              byte_done;

    assign byte_done = stb && !restart && (bit_cnt == LAST_BIT);

    always_comb begin
        wr.en   = byte_done;
        wr.idx  = cur_idx;
        wr.data = {din, shreg};
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            bit_cnt <= '0;
            shreg   <= '0;
            cur_idx <= '0;
        end else if (stb) begin
            if (byte_done) begin
                bit_cnt <= '0;
                shreg   <= '0;
                cur_idx <= (cur_idx >= len - 1'b1) ? '0 : cur_idx + 1'b1;
            end else begin
                bit_cnt <= bit_cnt + 1'b1;
                shreg   <= {din, shreg[DATA_W-2:1]};
            end
        end
    end

endmodule

// File: rtl/rxbuf_regs.sv
module rxbuf_regs
    import rxbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  host_t             h,
    input  logic              blk_done,
    input  logic [N_ERR-1:0]  err_evt,
    output logic [DATA_W-1:0] reg_rd,
    output bufmode_e          mode,
    output logic [N_STS-1:0]  sts,
    output logic [N_STS-1:0]  ien,
    output logic              irq_n
);
    logic [DATA_W-1:0] ctl1;
    logic [DATA_W-1:0] ctl2;
    logic              done_d;
    logic [N_STS-1:0]  sts_set;
    logic [N_STS-1:0]  sts_clr;

    assign sts_set = {blk_done && !done_d, err_evt};
    assign sts_clr = {N_STS{h.sel && h.rd && (h.addr == A_STS)}};
    assign mode    = bufmode_e'(ctl1[1:0]);
    assign irq_n   = ~|(sts & ien);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl1   <= '0;
            ctl2   <= '0;
            ien    <= '0;
            sts    <= '0;
            done_d <= 1'b0;
        end else begin
            done_d <= blk_done;
            sts    <= (sts & ~sts_clr) | sts_set;
            if (h.sel && !h.rd) begin
                case (h.addr)
                    A_IEN:   ien  <= h.wdata[N_STS-1:0];
                    A_CTL1:  ctl1 <= h.wdata;
                    A_CTL2:  ctl2 <= h.wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (h.addr[1:0])
            2'd0:    reg_rd = DATA_W'(sts);
            2'd1:    reg_rd = DATA_W'(ien);
            2'd2:    reg_rd = ctl1;
            default: reg_rd = ctl2;
        endcase
    end

endmodule

// File: rtl/rxbuf_top.sv
module rxbuf_top
    import rxbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              blk_start,
    input  logic              chs_stb,
    input  logic              chs_bit,
    input  logic              usr_stb,
    input  logic              usr_bit,
    input  logic              aux_stb,
    input  logic              aux_bit,
    input  logic [N_ERR-1:0]  err_evt,
    input  logic              h_cs,
    input  logic              h_rd,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [DATA_W-1:0] h_wdata,
    output logic [DATA_W-1:0] h_rdata,
    output logic [2:0]        flag,
    output logic              irq_n
);
    host_t             host;
    bufmode_e          mode;
    logic [DATA_W-1:0] reg_rd;
    logic [N_STS-1:0]  sts_q;
    logic [N_STS-1:0]  ien_q;
    logic              blk_done;

    logic              stb_v [N_STREAM];
    logic              bit_v [N_STREAM];
    logic [IDX_W-1:0]  len_v [N_STREAM];
    logic [IDX_W-1:0]  idx_v [N_STREAM];
    wr_t               wr_v  [N_STREAM];

    logic [DATA_W-1:0] mem [MEM_LO:MEM_HI];

    assign host = '{sel: h_cs, rd: h_rd, addr: h_addr, wdata: h_wdata};

    always_comb begin
        stb_v[S_CHS] = chs_stb;
        bit_v[S_CHS] = chs_bit;
        stb_v[S_USR] = usr_stb;
        bit_v[S_USR] = usr_bit;
        stb_v[S_AUX] = aux_stb && (mode == BM_CHS_AUX);
        bit_v[S_AUX] = aux_bit;
        for (int s = 0; s < N_STREAM; s++) begin
            len_v[s] = region_len(s, mode);
        end
    end

    for (genvar g = 0; g < N_STREAM; g++) begin : g_stream
        rxbuf_assembler u_asm (
            .clk     (clk),
            .rst     (rst),
            .restart (blk_start),
            .stb     (stb_v[g]),
            .din     (bit_v[g]),
            .len     (len_v[g]),
            .wr      (wr_v[g]),
            .cur_idx (idx_v[g])
        );
    end

    rxbuf_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .h        (host),
        .blk_done (blk_done),
        .err_evt  (err_evt),
        .reg_rd   (reg_rd),
        .mode     (mode),
        .sts      (sts_q),
        .ien      (ien_q),
        .irq_n    (irq_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = MEM_LO; a <= MEM_HI; a++) mem[a] <= '0;
        end else begin
            for (int s = 0; s < N_STREAM; s++) begin
                if (wr_v[s].en) mem[region_base(s) + wr_v[s].idx] <= wr_v[s].data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || blk_start) begin
            blk_done <= 1'b0;
        end else if (wr_v[S_CHS].en && (wr_v[S_CHS].idx == len_v[S_CHS] - 1'b1)) begin
            blk_done <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h_rdata <= '0;
        end else if (h_cs && h_rd) begin
            h_rdata <= (h_addr < ADDR_W'(MEM_LO)) ? reg_rd : mem[h_addr];
        end
    end

    assign flag[0] = idx_v[S_USR] >= (len_v[S_USR] >> 1);
    assign flag[1] = idx_v[S_CHS] >= (len_v[S_CHS] >> 1);
    assign flag[2] = blk_done;

endmodule

// File: rtl/rxbuf_chk.sv
module rxbuf_chk
    import rxbuf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              blk_start,
    input logic [N_ERR-1:0]  err_evt,
    input logic              h_cs,
    input logic              h_rd,
    input logic [ADDR_W-1:0] h_addr,
    input logic [DATA_W-1:0] h_rdata,
    input logic [2:0]        flag,
    input logic              irq_n,
    input logic [N_STS-1:0]  sts,
    input logic [N_STS-1:0]  ien
);
    AST_IEN_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
        (h_cs && h_rd && h_addr == A_IEN) |=> (h_rdata[7:4] == 4'h0)); // R2

    AST_DONE_DROPS: assert property (@(posedge clk) disable iff (rst)
        blk_start |=> !flag[2]); // R7

    AST_EVT_STICKS: assert property (@(posedge clk) disable iff (rst)
        err_evt[0] |=> sts[0]); // R8

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (h_cs && h_rd && h_addr == A_STS && err_evt == '0) |=> (sts[N_ERR-1:0] == '0)); // R8

    AST_DONE_RISE_SETS: assert property (@(posedge clk) disable iff (rst)
        $rose(flag[2]) |=> sts[N_ERR]); // R9

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (ien == '0) |-> irq_n); // R10

endmodule

bind rxbuf_top rxbuf_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .blk_start (blk_start),
    .err_evt   (err_evt),
    .h_cs      (h_cs),
    .h_rd      (h_rd),
    .h_addr    (h_addr),
    .h_rdata   (h_rdata),
    .flag      (flag),
    .irq_n     (irq_n),
    .sts       (sts_q),
    .ien       (ien_q)
);

// File: tb/sim_rxbuf_top.sv
module sim_rxbuf_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       blk_start, chs_stb, chs_bit, usr_stb, usr_bit, aux_stb, aux_bit;
    logic [2:0] err_evt;
    logic       h_cs, h_rd;
    logic [4:0] h_addr;
    logic [7:0] h_wdata;
    logic [7:0] h_rdata;
    logic [2:0] flag;
    logic       irq_n;

    int         n_checks = 0;
    int         n_errors = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic       rd_fire = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxbuf_top u0 (
        .clk(clk), .rst(rst), .blk_start(blk_start),
        .chs_stb(chs_stb), .chs_bit(chs_bit),
        .usr_stb(usr_stb), .usr_bit(usr_bit),
        .aux_stb(aux_stb), .aux_bit(aux_bit),
        .err_evt(err_evt), .h_cs(h_cs), .h_rd(h_rd),
        .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .flag(flag), .irq_n(irq_n)
    );

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // monitor: compares read data against the scoreboard queue
    always @(posedge clk) rd_fire <= h_cs && h_rd && !rst;
    always @(negedge clk) begin
        if (rd_fire) begin
            if (exp_q.size() == 0) begin
                chk("scoreboard-empty", 8'h01, 8'h00);
            end else begin
                chk(tag_q.pop_front(), h_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic host_read(input logic [4:0] a, input logic [7:0] e, input string tag);
        h_cs = 1'b1; h_rd = 1'b1; h_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        tick();
        h_cs = 1'b0;
    endtask

    task automatic host_write(input logic [4:0] a, input logic [7:0] d);
        h_cs = 1'b1; h_rd = 1'b0; h_addr = a; h_wdata = d;
        tick();
        h_cs = 1'b0;
    endtask

    task automatic pulse_blk();
        blk_start = 1'b1; tick(); blk_start = 1'b0;
    endtask

    task automatic send_chs(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            chs_stb = 1'b1; chs_bit = b[i]; tick();
        end
        chs_stb = 1'b0;
    endtask

    task automatic send_usr(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            usr_stb = 1'b1; usr_bit = b[i]; tick();
        end
        usr_stb = 1'b0;
    endtask

    task automatic send_aux(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            aux_stb = 1'b1; aux_bit = b[i]; tick();
        end
        aux_stb = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        rst = 1'b1; blk_start = 0; chs_stb = 0; chs_bit = 0; usr_stb = 0; usr_bit = 0;
        aux_stb = 0; aux_bit = 0; err_evt = 0; h_cs = 0; h_rd = 0; h_addr = 0; h_wdata = 0;
        repeat (3) tick();
        rst = 1'b0;

        // R1 reset state
        chk("R1 flag", {5'b0, flag}, 8'h00);
        chk("R1 irq_n", {7'b0, irq_n}, 8'h01);
        host_read(5'h00, 8'h00, "R1 status");
        host_read(5'h01, 8'h00, "R1 enable");
        host_read(5'h02, 8'h00, "R1 ctl1");
        host_read(5'h03, 8'h00, "R1 ctl2");
        host_read(5'h08, 8'h00, "R1 buffer");

        // R2 register access
        host_write(5'h01, 8'hFF);
        host_read(5'h01, 8'h0F, "R2 enable reserved");
        host_write(5'h03, 8'hA5);
        host_read(5'h03, 8'hA5, "R2 ctl2");
        host_write(5'h02, 8'hC0);
        host_read(5'h02, 8'hC0, "R2 ctl1");
        host_write(5'h01, 8'h00);

        // R3/R6/R7 mode 0: 24-byte channel-status region
        pulse_blk();
        for (int i = 0; i < 24; i++) begin
            send_chs(8'(i * 7 + 3));
            if (i == 10) chk("R6 flag1 lower", {7'b0, flag[1]}, 8'h00);
            if (i == 11) chk("R6 flag1 upper", {7'b0, flag[1]}, 8'h01);
            if (i == 22) chk("R7 flag2 early", {7'b0, flag[2]}, 8'h00);
        end
        chk("R7 flag2 set", {7'b0, flag[2]}, 8'h01);
        chk("R3 wrap flag1", {7'b0, flag[1]}, 8'h00);
        host_read(5'h08, 8'h03, "R3 first cs byte");
        host_read(5'h1F, 8'hA4, "R3 last cs byte");
        host_read(5'h00, 8'h08, "R9 done status");
        host_read(5'h00, 8'h00, "R9 no re-set while high");

        pulse_blk();
        chk("R7 flag after blk_start", {5'b0, flag}, 8'h00);

        // R4/R6 user region
        send_usr(8'h11);
        send_usr(8'h22);
        chk("R6 flag0 upper", {7'b0, flag[0]}, 8'h01);
        send_usr(8'h33);
        send_usr(8'h44);
        chk("R6 flag0 wrap", {7'b0, flag[0]}, 8'h00);
        host_read(5'h04, 8'h11, "R4 user first");
        host_read(5'h07, 8'h44, "R4 user last");

        // R5/R3 mode 1
        host_write(5'h02, 8'h01);
        pulse_blk();
        for (int i = 0; i < 16; i++) send_aux(8'(8'h80 + i));
        host_read(5'h10, 8'h80, "R5 aux first");
        host_read(5'h1F, 8'h8F, "R5 aux last");
        for (int i = 0; i < 8; i++) begin
            send_chs(8'(8'h50 + i));
            if (i == 3) chk("R6 flag1 mode1", {7'b0, flag[1]}, 8'h01);
        end
        chk("R3 short region done", {7'b0, flag[2]}, 8'h01);
        host_read(5'h0F, 8'h57, "R3 short last");
        host_read(5'h00, 8'h08, "R9 done status mode1");

        // R5 aux ignored in mode 2
        host_write(5'h02, 8'h02);
        pulse_blk();
        send_aux(8'hEE);
        host_read(5'h10, 8'h80, "R5 aux ignored");

        // R12 host write to buffer ignored
        host_write(5'h08, 8'hFF);
        host_read(5'h08, 8'h50, "R12 buffer write ignored");

        // R8 sticky and read-clear
        err_evt = 3'b010; tick(); err_evt = 3'b000;
        host_read(5'h00, 8'h02, "R8 sticky");
        host_read(5'h00, 8'h00, "R8 cleared");
        err_evt = 3'b001;
        host_read(5'h00, 8'h00, "R8 read with event");
        err_evt = 3'b000;
        host_read(5'h00, 8'h01, "R8 event wins");

        // R10 interrupt masking
        err_evt = 3'b100; tick(); err_evt = 3'b000;
        chk("R10 masked", {7'b0, irq_n}, 8'h01);
        host_write(5'h01, 8'h04);
        chk("R10 enabled", {7'b0, irq_n}, 8'h00);
        host_read(5'h00, 8'h04, "R10 status");
        chk("R10 released", {7'b0, irq_n}, 8'h01);
        host_write(5'h01, 8'h00);

        // R11 read collides with byte store
        pulse_blk();
        for (int i = 0; i < 7; i++) begin
            usr_stb = 1'b1; usr_bit = 8'h5A >> i; tick();
        end
        usr_bit = 1'b0;
        h_cs = 1'b1; h_rd = 1'b1; h_addr = 5'h04;
        exp_q.push_back(8'h11); tag_q.push_back("R11 old value");
        tick();
        usr_stb = 1'b0; h_cs = 1'b0;
        host_read(5'h04, 8'h5A, "R11 new value");

        repeat (3) tick();
        summary();
    end

endmodule